// File: doc/BRIEF.md
# Capture Timebase Counter

This block is the free-running time reference of an input-capture unit. A 24-bit register counts upward, one step per increment pulse. The pulse comes either from a prescaled version of the block clock or from the synchronized rising edges of one of three capture inputs. Capture channels sample this count when they see an edge. Those channels sit outside this block and hand it one-cycle event pulses.

The counter can raise a compare-match flag when an increment lands on a programmed compare value. It can return to zero on that match, or on any capture event. It can also reload the compare value into the count when a selected trigger fires. Two sticky flags record compare matches and rollovers from the top value to zero. Software clears them by writing ones, and each has an interrupt enable. All control fields arrive as plain inputs from a register bank that is not part of this block.

Top module: `capt_timebase`

## Requirements
- R1: After reset the count, both flags and the interrupt are 0. The count steps by one per increment pulse only while `en_i` and `start_i` are both 1. Otherwise it holds its value.
- R2: With `src_sel_i` = 0, an increment pulse occurs once every N clocks while running. `psc_sel_i` codes 0..7 give N = 1, 4, 16, 32, 64, 96, 112, 128. The prescaler restarts from zero whenever the counter is stopped.
- R3: An increment taken at the all-ones count wraps it to 0 and sets `ovf_flag_o` on the same edge.
- R4: With `src_sel_i` = k (1..3), the count steps once per rising edge of `cap_in_i[k-1]`. The input passes two synchronizer flops, so the step lands on the third clock edge after the input rises.
- R5: With `cmp_en_i` = 1, an increment whose result equals `cmp_val_i` sets `cmp_flag_o`. With `cmp_en_i` = 0 the flag is never set.
- R6: With `clr_on_cmp_i` = 1, a compare match puts 0 in the count instead of the compare value.
- R7: With `clr_on_cap_i` = 1, any bit of `cap_evt_i` set while running puts 0 in the count.
- R8: With `rld_en_i` = 1, the trigger picked by `rld_sel_i` copies `cmp_val_i` into the count. Codes 000, 001 and 010 select capture events 0, 1 and 2, and 100 selects the rollover event. Every other code selects nothing.
- R9: Within one cycle a reload wins over a clear, and a clear wins over an increment.
- R10: A flag stays set until `flag_clr_i` has a 1 in its bit (bit 0 compare, bit 1 overflow). A clear in the same cycle as a new hardware set leaves the flag at 1.
- R11: `irq_o` is registered. It is 1 when (compare flag and `cmp_ie_i`) or (overflow flag and `ovf_ie_i`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Timebase enable |
| start_i | input | 1 | Counter run request |
| psc_sel_i | input | 3 | Prescale divisor code |
| src_sel_i | input | 2 | Increment source: 0 prescaler, 1..3 capture input 0..2 |
| cmp_val_i | input | 24 | Compare and reload value |
| cmp_en_i | input | 1 | Compare detection enable |
| clr_on_cmp_i | input | 1 | Zero the count on compare match |
| clr_on_cap_i | input | 1 | Zero the count on any capture event |
| rld_en_i | input | 1 | Reload enable |
| rld_sel_i | input | 3 | Reload trigger code |
| cap_in_i | input | 3 | Raw capture inputs, used as count sources |
| cap_evt_i | input | 3 | One-cycle capture event pulses from the channels |
| flag_clr_i | input | 2 | Write-one clear: bit 0 compare, bit 1 overflow |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| count_o | output | 24 | Live count |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky rollover flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 24-bit count, three capture channels and a two-flop synchronizer. With a full 24-bit width, a rollover would take millions of cycles if the count had to climb there. The bench therefore uses reloads of compare values just below all-ones to bring the wrap and the reload-on-rollover trigger into a few dozen cycles. Every prescale code, including the divisors that are not powers of two, runs long enough to show several periods. Random mixes of sources, events and clears then probe the priority order and the same-cycle set-versus-clear case.

// File: rtl/capt_pkg.sv
package capt_pkg;

  // Width of the prescale counter; the largest divisor is 128.
  localparam int PSC_W = 7;

  // Reload trigger code that selects the rollover event.
  localparam logic [2:0] RLD_SEL_OVF = 3'b100;

  // Terminal value (divisor minus one) for each prescale code.
  function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] sel);
    case (sel)
      3'd0:    psc_last = 7'd0;
      3'd1:    psc_last = 7'd3;
      3'd2:    psc_last = 7'd15;
      3'd3:    psc_last = 7'd31;
      3'd4:    psc_last = 7'd63;
      3'd5:    psc_last = 7'd95;
      3'd6:    psc_last = 7'd111;
      default: psc_last = 7'd127;
    endcase
  endfunction

endpackage

// File: rtl/capt_prescaler.sv
module capt_prescaler
  import capt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);

  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] last_w;

  assign last_w = psc_last(sel_i);
  // Compare with >= so a shrinking divisor never strands the counter.
  assign tick_o = run_i && (div_q >= last_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (!run_i || tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/capt_edge_detect.sv
module capt_edge_detect #(
  parameter int NCH    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  output logic [NCH-1:0] rise_o
);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic [STAGES:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0;
        end else begin
          sh_q <= {sh_q[STAGES-1:0], pin_i[g]};
        end
      end
      assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    end
  endgenerate

endmodule

// File: rtl/capt_count_core.sv
module capt_count_core
  import capt_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int NCH   = 3,
  localparam int SRC_W = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic             tick_i,
  input  logic [NCH-1:0]   rise_i,
  input  logic [NCH-1:0]   cap_evt_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             cmp_en_i,
  input  logic             clr_on_cmp_i,
  input  logic             clr_on_cap_i,
  input  logic             rld_en_i,
  input  logic [2:0]       rld_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             inc_o,
  output logic             cmp_hit_o,
  output logic             ovf_evt_o,
  output logic             rld_trig_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             inc_src;

  // Pick the increment source.
  always_comb begin
    inc_src = 1'b0;
    if (src_sel_i == '0) begin
      inc_src = tick_i;
    end
    for (int i = 0; i < NCH; i++) begin
      if (src_sel_i == SRC_W'(i + 1)) begin
        inc_src = rise_i[i];
      end
    end
  end

  assign inc_o     = run_i && inc_src;
  assign cnt_inc   = cnt_q + 1'b1;
  assign ovf_evt_o = inc_o && (cnt_q == {CNT_W{1'b1}});
  assign cmp_hit_o = cmp_en_i && inc_o && (cnt_inc == cmp_val_i);

  // Reload trigger decode: channel codes, then the rollover code.
  always_comb begin
    rld_trig_o = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (rld_sel_i == 3'(i)) begin
        rld_trig_o = cap_evt_i[i];
      end
    end
    if (rld_sel_i == RLD_SEL_OVF) begin
      rld_trig_o = ovf_evt_o;
    end
  end

  // Priority: reload, then clear, then increment.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run_i) begin
      if (rld_en_i && rld_trig_o) begin
        cnt_q <= cmp_val_i;
      end else if ((clr_on_cmp_i && cmp_hit_o) || (clr_on_cap_i && (|cap_evt_i))) begin
        cnt_q <= '0;
      end else if (inc_o) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/capt_flag_w1c.sv
module capt_flag_w1c #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] ie_i,
  output logic [NFLAG-1:0] flag_o,
  output logic             irq_o
);

  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_d;

  // A hardware set in the same cycle outweighs a software clear.
  assign flag_d = (flag_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_o  <= |(flag_d & ie_i);
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/capt_timebase.sv
module capt_timebase
  import capt_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int NCH      = 3,
  parameter int SYNC_STG = 2,
  localparam int SRC_W   = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [2:0]       psc_sel_i,
  input  logic [SRC_W-1:0] src_sel_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             cmp_en_i,
  input  logic             clr_on_cmp_i,
  input  logic             clr_on_cap_i,
  input  logic             rld_en_i,
  input  logic [2:0]       rld_sel_i,
  input  logic [NCH-1:0]   cap_in_i,
  input  logic [NCH-1:0]   cap_evt_i,
  input  logic [1:0]       flag_clr_i,
  input  logic             cmp_ie_i,
  input  logic             ovf_ie_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);

  logic           run_w;
  logic           tick_w;
  logic [NCH-1:0] rise_w;
  logic           inc_w;
  logic           cmp_hit_w;
  logic           ovf_evt_w;
  logic           rld_trig_w;
  logic [1:0]     flags_w;

  assign run_w = en_i && start_i;

  capt_prescaler u_psc (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_w),
    .sel_i  (psc_sel_i),
    .tick_o (tick_w)
  );

  capt_edge_detect #(
    .NCH    (NCH),
    .STAGES (SYNC_STG)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (cap_in_i),
    .rise_o (rise_w)
  );

  capt_count_core #(
    .CNT_W (CNT_W),
    .NCH   (NCH)
  ) u_core (
    .clk          (clk),
    .rst          (rst),
    .run_i        (run_w),
    .src_sel_i    (src_sel_i),
    .tick_i       (tick_w),
    .rise_i       (rise_w),
    .cap_evt_i    (cap_evt_i),
    .cmp_val_i    (cmp_val_i),
    .cmp_en_i     (cmp_en_i),
    .clr_on_cmp_i (clr_on_cmp_i),
    .clr_on_cap_i (clr_on_cap_i),
    .rld_en_i     (rld_en_i),
    .rld_sel_i    (rld_sel_i),
    .count_o      (count_o),
    .inc_o        (inc_w),
    .cmp_hit_o    (cmp_hit_w),
    .ovf_evt_o    (ovf_evt_w),
    .rld_trig_o   (rld_trig_w)
  );

  capt_flag_w1c #(
    .NFLAG (2)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  ({ovf_evt_w, cmp_hit_w}),
    .clr_i  (flag_clr_i),
    .ie_i   ({ovf_ie_i, cmp_ie_i}),
    .flag_o (flags_w),
    .irq_o  (irq_o)
  );

  assign cmp_flag_o = flags_w[0];
  assign ovf_flag_o = flags_w[1];

endmodule

// File: rtl/capt_timebase_chk.sv
module capt_timebase_chk #(
  parameter int CNT_W = 24,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             start_i,
  input logic [CNT_W-1:0] cmp_val_i,
  input logic             clr_on_cmp_i,
  input logic             clr_on_cap_i,
  input logic             rld_en_i,
  input logic [NCH-1:0]   cap_evt_i,
  input logic [1:0]       flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             cmp_flag_o,
  input logic             ovf_flag_o,
  input logic             irq_o,
  input logic             cmp_hit,
  input logic             ovf_evt,
  input logic             rld_trig
);

  logic run;
  assign run = en_i && start_i;

  p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count_o));

  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag_o);

  p_match_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |=> cmp_flag_o);

  p_no_spurious_match_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmp_flag_o && !cmp_hit) |=> !cmp_flag_o);

  p_match_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (run && clr_on_cmp_i && cmp_hit && !(rld_en_i && rld_trig)) |=> (count_o == '0));

  p_event_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (run && clr_on_cap_i && (|cap_evt_i) && !(rld_en_i && rld_trig)) |=> (count_o == '0));

  // R9: the reload value appears even when a clear is also requested.
  p_reload_loads_r8: assert property (@(posedge clk) disable iff (rst)
    (run && rld_en_i && rld_trig) |=> (count_o == $past(cmp_val_i)));

  p_w1c_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i[0] && !cmp_hit) |=> !cmp_flag_o);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (cmp_flag_o || ovf_flag_o));

endmodule

bind capt_timebase capt_timebase_chk #(
  .CNT_W (CNT_W),
  .NCH   (NCH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en_i         (en_i),
  .start_i      (start_i),
  .cmp_val_i    (cmp_val_i),
  .clr_on_cmp_i (clr_on_cmp_i),
  .clr_on_cap_i (clr_on_cap_i),
  .rld_en_i     (rld_en_i),
  .cap_evt_i    (cap_evt_i),
  .flag_clr_i   (flag_clr_i),
  .count_o      (count_o),
  .cmp_flag_o   (cmp_flag_o),
  .ovf_flag_o   (ovf_flag_o),
  .irq_o        (irq_o),
  .cmp_hit      (cmp_hit_w),
  .ovf_evt      (ovf_evt_w),
  .rld_trig     (rld_trig_w)
);

// File: tb/capt_timebase_bench.sv
module capt_timebase_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW  = 24;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en_i = 0, start_i = 0;
  logic [2:0]     psc_sel_i = 0;
  logic [1:0]     src_sel_i = 0;
  logic [CW-1:0]  cmp_val_i = 0;
  logic           cmp_en_i = 0, clr_on_cmp_i = 0, clr_on_cap_i = 0, rld_en_i = 0;
  logic [2:0]     rld_sel_i = 0;
  logic [NCH-1:0] cap_in_i = 0, cap_evt_i = 0;
  logic [1:0]     flag_clr_i = 0;
  logic           cmp_ie_i = 0, ovf_ie_i = 0;
  logic [CW-1:0]  count_o;
  logic           cmp_flag_o, ovf_flag_o, irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  capt_timebase u_capt_timebase (
    .clk(clk), .rst(rst), .en_i(en_i), .start_i(start_i),
    .psc_sel_i(psc_sel_i), .src_sel_i(src_sel_i), .cmp_val_i(cmp_val_i),
    .cmp_en_i(cmp_en_i), .clr_on_cmp_i(clr_on_cmp_i), .clr_on_cap_i(clr_on_cap_i),
    .rld_en_i(rld_en_i), .rld_sel_i(rld_sel_i), .cap_in_i(cap_in_i),
    .cap_evt_i(cap_evt_i), .flag_clr_i(flag_clr_i), .cmp_ie_i(cmp_ie_i),
    .ovf_ie_i(ovf_ie_i), .count_o(count_o), .cmp_flag_o(cmp_flag_o),
    .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1";

  // Expected state, derived from the requirements.
  int             e_div;
  logic [NCH-1:0] e_p1, e_p2, e_p3;
  logic [CW-1:0]  e_cnt;
  logic           e_cf, e_of, e_irq;

  function automatic int divisor(input logic [2:0] code);
    case (code)
      3'd0: return 1;   3'd1: return 4;   3'd2: return 16;  3'd3: return 32;
      3'd4: return 64;  3'd5: return 96;  3'd6: return 112; default: return 128;
    endcase
  endfunction

  task automatic exp_reset();
    e_div = 0; e_p1 = 0; e_p2 = 0; e_p3 = 0;
    e_cnt = 0; e_cf = 0; e_of = 0; e_irq = 0;
  endtask

  // Advance the expectation by one clock using the inputs now applied.
  task automatic exp_step();
    logic run, tick, inc, wrap, hit, trig;
    logic [NCH-1:0] rise;
    logic [CW-1:0] nxt;
    run  = en_i && start_i;
    tick = run && (e_div >= divisor(psc_sel_i) - 1);
    e_div = (!run || tick) ? 0 : e_div + 1;
    rise = e_p2 & ~e_p3;
    e_p3 = e_p2; e_p2 = e_p1; e_p1 = cap_in_i;
    inc  = run && ((src_sel_i == 0) ? tick : rise[src_sel_i - 1]);
    nxt  = e_cnt + 1'b1;
    wrap = inc && (e_cnt == {CW{1'b1}});
    hit  = cmp_en_i && inc && (nxt == cmp_val_i);
    case (rld_sel_i)
      3'b000:  trig = cap_evt_i[0];
      3'b001:  trig = cap_evt_i[1];
      3'b010:  trig = cap_evt_i[2];
      3'b100:  trig = wrap;
      default: trig = 1'b0;
    endcase
    if (run) begin
      if (rld_en_i && trig)                                     e_cnt = cmp_val_i;
      else if ((clr_on_cmp_i && hit) || (clr_on_cap_i && |cap_evt_i)) e_cnt = '0;
      else if (inc)                                             e_cnt = nxt;
    end
    e_cf  = (e_cf & ~flag_clr_i[0]) | hit;
    e_of  = (e_of & ~flag_clr_i[1]) | wrap;
    e_irq = (e_cf & cmp_ie_i) | (e_of & ovf_ie_i);
  endtask

  task automatic chk(input string what, input logic [CW-1:0] got, input logic [CW-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", phase, what, got, want);
    end
  endtask

  task automatic cycle();
    exp_step();
    @(posedge clk);
    @(negedge clk);
    chk("count", count_o, e_cnt);
    chk("cmp_flag", CW'(cmp_flag_o), CW'(e_cf));
    chk("ovf_flag", CW'(ovf_flag_o), CW'(e_of));
    chk("irq", CW'(irq_o), CW'(e_irq));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    cap_evt_i = m;
    cycle();
    cap_evt_i = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd77331));
    exp_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("reset count", count_o, '0);
    chk("reset flags", CW'({cmp_flag_o, ovf_flag_o, irq_o}), '0);

    // R1 counting and holding
    phase = "R1";
    en_i = 1; start_i = 1; cycles(20);
    chk("count after 20 steps", count_o, 24'd20);
    start_i = 0; cycles(10);
    chk("held with start low", count_o, 24'd20);
    start_i = 1; en_i = 0; cycles(10);
    en_i = 1;

    // R2 every prescale code
    phase = "R2";
    for (int c = 0; c < 8; c++) begin
      psc_sel_i = 3'(c);
      cycles(300);
    end
    psc_sel_i = 0;

    // R4 capture inputs as count source
    phase = "R4";
    for (int s = 1; s < 4; s++) begin
      src_sel_i = 2'(s);
      for (int i = 0; i < 150; i++) begin
        if ($urandom_range(0, 2) == 0) cap_in_i = cap_in_i ^ 3'(1 << $urandom_range(0, 2));
        cycle();
      end
    end
    src_sel_i = 0;

    // R5 compare flag, with and without enable
    phase = "R5";
    start_i = 0; cycle(); clr_on_cap_i = 1; pulse(3'b001); clr_on_cap_i = 0;
    start_i = 1; cmp_val_i = 24'd10; cmp_en_i = 0; cycles(15);
    chk("no flag while compare off", CW'(cmp_flag_o), '0);
    flag_clr_i = 2'b11; cycle(); flag_clr_i = 0;
    clr_on_cap_i = 1; pulse(3'b010); clr_on_cap_i = 0;
    cmp_en_i = 1; cycles(10);
    chk("flag at match", CW'(cmp_flag_o), 24'd1);

    // R6 clear on compare
    phase = "R6";
    clr_on_cmp_i = 1; cmp_val_i = 24'd7; cycles(40);
    clr_on_cmp_i = 0;

    // R7 clear on capture event
    phase = "R7";
    clr_on_cap_i = 1;
    for (int i = 0; i < 6; i++) begin cycles(5); pulse(3'(1 << (i % 3))); end
    chk("zero after event", count_o, '0);
    clr_on_cap_i = 0;

    // R8 every reload code, including rollover
    phase = "R8";
    cmp_en_i = 0; rld_en_i = 1; cmp_val_i = 24'hFFFFF8;
    for (int c = 0; c < 8; c++) begin
      rld_sel_i = 3'(c);
      pulse(3'b001); cycles(3); pulse(3'b010); cycles(3); pulse(3'b100); cycles(12);
      flag_clr_i = 2'b11; cycle(); flag_clr_i = 0;
    end
    rld_en_i = 0; rld_sel_i = 0;

    // R3 rollover
    phase = "R3";
    rld_en_i = 1; cmp_val_i = 24'hFFFFF0; pulse(3'b001); rld_en_i = 0;
    chk("reloaded near top", count_o, 24'hFFFFF0);
    cycles(20);
    chk("wrapped count", count_o, 24'd4);
    chk("overflow flag", CW'(ovf_flag_o), 24'd1);

    // R9 priority
    phase = "R9";
    rld_en_i = 1; rld_sel_i = 3'b000; clr_on_cap_i = 1; cmp_val_i = 24'h000100;
    pulse(3'b001);
    chk("reload beats clear", count_o, 24'h000100);
    pulse(3'b010);
    chk("clear beats increment", count_o, '0);
    rld_en_i = 0; clr_on_cap_i = 0;

    // R10 write-one-clear against new sets
    phase = "R10";
    cmp_en_i = 1; clr_on_cmp_i = 1; cmp_val_i = 24'd5;
    flag_clr_i = 2'b01; cycles(30);
    flag_clr_i = 0; cycles(5);
    flag_clr_i = 2'b10; cycle(); flag_clr_i = 0;
    chk("overflow flag cleared", CW'(ovf_flag_o), '0);

    // R11 interrupt enables
    phase = "R11";
    cmp_ie_i = 1; cycles(12);
    cmp_ie_i = 0; ovf_ie_i = 1; cycles(12);
    cmp_en_i = 0; clr_on_cmp_i = 0; ovf_ie_i = 0;

    // Random mix (all requirements)
    phase = "R1 to R11 random";
    for (int seg = 0; seg < 30; seg++) begin
      en_i = ($urandom_range(0, 7) != 0);
      start_i = ($urandom_range(0, 7) != 0);
      psc_sel_i = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
      src_sel_i = 2'($urandom_range(0, 3));
      cmp_val_i = ($urandom_range(0, 3) == 0) ? 24'hFFFFFC : 24'($urandom_range(0, 40));
      cmp_en_i = 1'($urandom); clr_on_cmp_i = 1'($urandom);
      clr_on_cap_i = ($urandom_range(0, 3) == 0);
      rld_en_i = 1'($urandom); rld_sel_i = 3'($urandom_range(0, 7));
      cmp_ie_i = 1'($urandom); ovf_ie_i = 1'($urandom);
      for (int i = 0; i < 200; i++) begin
        if ($urandom_range(0, 3) == 0) cap_in_i = 3'($urandom);
        cap_evt_i  = ($urandom_range(0, 15) == 0) ? 3'($urandom) : 3'b000;
        flag_clr_i = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
        cycle();
      end
      cap_evt_i = 0; flag_clr_i = 0;
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired in phase %s", phase);
      summary();
      $finish;
    end
  end

endmodule